// File: doc/BRIEF.md
# Burst Column Address Generator

This block generates the column address for each beat of one SDRAM read or write burst. A burst begins when `start` is sampled high on an enabled clock. The block takes the start column and a mode word that holds the burst-length code, the wrap-type bit and the single-beat-write bit. It then presents one column address per enabled clock until one of three things happens: the burst reaches its length, `stop` arrives, or a new `start` replaces it.

Two orderings are supported, both inside the aligned block of the burst length: a sequential wrap and an interleaved (XOR) order. A full-page mode walks all 256 columns in sequence and never ends by itself. A mode bit forces every write burst to a single beat. Mode words that are illegal raise `mode_err` and start nothing. While `cke` is low, every piece of state is frozen.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid`, `last` and `mode_err` are 0.
- R2: A `start` with a legal mode, sampled on an enabled edge, makes `valid`=1 and `col_addr`=`start_col` after that edge. The length code in `mode_word[2:0]` gives 000=1, 001=2, 010=4, 011=8 or 111=full page beats. A finite burst produces exactly that many beats on enabled edges, with `last`=1 on the final beat, and `valid` falls on the next enabled edge.
- R3: With `mode_word[3]`=0 (sequential), beat k of a burst of length L has low log2(L) bits equal to (start + k) mod L. The bits above that field equal those of `start_col`.
- R4: With `mode_word[3]`=1 (interleave), beat k has low log2(L) bits equal to start XOR k. The upper bits are unchanged.
- R5: A full-page burst (code 111, `mode_word[3]`=0) produces (start_col + k) mod 256 on every beat and never raises `last`.
- R6: With `mode_word[9]`=1, a write burst (`is_write`=1) has exactly one beat, with `last`=1. A read burst under the same mode word uses the programmed length.
- R7: A `start` with length code 100, 101 or 110, or with code 111 and `mode_word[3]`=1, makes `mode_err`=1 for one enabled cycle and starts no burst. A burst that is already running continues unchanged.
- R8: `stop` sampled on an enabled edge during a burst (with no `start`) makes `valid`=0 after that edge, whatever the length.
- R9: When `cke` is low, `col_addr`, `valid`, `last` and `mode_err` hold their values, and `start` and `stop` have no effect.
- R10: A legal `start` during a running burst restarts the burst from the new start column, even if `stop` is high on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes all state |
| start | input | 1 | Begin a burst |
| is_write | input | 1 | Burst is a write |
| stop | input | 1 | End the running burst |
| start_col | input | COL_W | Start column address |
| mode_word | input | MODE_W | Length code [2:0], wrap type [3], single-beat write [9] |
| col_addr | output | COL_W | Column address of the current beat |
| valid | output | 1 | A beat is present |
| last | output | 1 | Final beat of a finite burst |
| mode_err | output | 1 | Start was refused for an illegal mode |

## Verification
Every output is registered. The first beat and `mode_err` therefore appear after the edge that samples `start`. Each later beat, the drop of `valid` after `last` or `stop`, and the effect of a restart all appear after the next enabled edge. A low `cke` pushes each of these results back by one edge for every suspended cycle. The bench drives inputs on the falling edge. A behavioural model then advances on each rising edge, and the model and the ports are compared on the following falling edge, so every result is judged in the cycle it is due.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              start,
  input  logic              is_write,
  input  logic              stop,
  input  logic [COL_W-1:0]  start_col,
  input  logic [MODE_W-1:0] mode_word,
  output logic [COL_W-1:0]  col_addr,
  output logic              valid,
  output logic              last,
  output logic              mode_err
);
  localparam int WRAP_BIT = 3;
  localparam int SBW_BIT  = 9;
  localparam logic [2:0] PAGE_CODE = 3'b111;

  logic [2:0]       len_code;
  logic             ilv_in, bad_mode, single_wr, page_in;
  logic [COL_W-1:0] new_mask;

  logic [COL_W-1:0] base_q, beat_q, mask_q, col_q;
  logic             ilv_q, page_q, valid_q, last_q, err_q;
  logic [COL_W-1:0] beat_nx, addr_nx;

  assign len_code  = mode_word[2:0];
  assign ilv_in    = mode_word[WRAP_BIT];
  assign single_wr = is_write & mode_word[SBW_BIT];
  assign bad_mode  = (len_code inside {3'd4, 3'd5, 3'd6}) ||
                     (len_code == PAGE_CODE && ilv_in);
  assign page_in   = (len_code == PAGE_CODE) && !single_wr;

  always_comb begin
    if (single_wr)
      new_mask = '0;
    else if (len_code == PAGE_CODE)
      new_mask = '1;
    else
      new_mask = COL_W'((32'd1 << len_code[1:0]) - 32'd1);
  end

  function automatic logic [COL_W-1:0] beat_addr(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k,
    input logic [COL_W-1:0] m, input logic il);
    logic [COL_W-1:0] low;
    low = il ? (b ^ k) : (b + k);
    return (b & ~m) | (low & m);
  endfunction

  assign beat_nx = beat_q + 1'b1;
  assign addr_nx = beat_addr(base_q, beat_nx, mask_q, ilv_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      col_q   <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (cke) begin
      err_q <= start & bad_mode;
      if (start && !bad_mode) begin
        base_q  <= start_col;
        beat_q  <= '0;
        mask_q  <= new_mask;
        ilv_q   <= ilv_in;
        page_q  <= page_in;
        col_q   <= start_col;
        valid_q <= 1'b1;
        last_q  <= (new_mask == '0);
      end else if (valid_q && (stop || last_q)) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else if (valid_q) begin
        beat_q <= beat_nx;
        col_q  <= addr_nx;
        last_q <= !page_q && (beat_nx == mask_q);
      end
    end
  end

  assign col_addr = col_q;
  assign valid    = valid_q;
  assign last     = last_q;
  assign mode_err = err_q;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              start,
  input logic              is_write,
  input logic              stop,
  input logic [COL_W-1:0]  start_col,
  input logic [MODE_W-1:0] mode_word,
  input logic [COL_W-1:0]  col_addr,
  input logic              valid,
  input logic              last,
  input logic              mode_err
);
  logic illegal;
  assign illegal = (mode_word[2:0] == 3'd4) || (mode_word[2:0] == 3'd5) ||
                   (mode_word[2:0] == 3'd6) ||
                   (mode_word[2:0] == 3'd7 && mode_word[3]);

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);  // R2
  AST_START_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && !illegal |=> valid && col_addr == $past(start_col));  // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke && valid && last && !start |=> !valid);  // R2
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && !illegal && mode_word[2:0] == 3'd7 && !(is_write && mode_word[9]) |=> !last);  // R5
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && !illegal && is_write && mode_word[9] |=> last);  // R6
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && illegal |=> mode_err);  // R7
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    cke && start && illegal && !valid |=> !valid);  // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke && stop && !start && valid |=> !valid);  // R8
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col_addr) && $stable(valid) && $stable(last) && $stable(mode_err));  // R9
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, start = 1'b0, is_write = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [9:0] mode_word = '0;
  logic [7:0] col_addr;
  logic       valid, last, mode_err;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  int m_valid = 0, m_last = 0, m_err = 0, m_beat = 0, m_len = 1, m_start = 0, m_ilv = 0, m_addr = 0;
  int seen_last = 0;

  always #10 clk = ~clk;

  burst_col_gen u_dut (.clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .is_write(is_write),
    .stop(stop), .start_col(start_col), .mode_word(mode_word), .col_addr(col_addr),
    .valid(valid), .last(last), .mode_err(mode_err));

  function automatic int addr_of(int s, int k, int len, int il);
    int off, blk;
    if (len == 0) return (s + k) % 256;
    off = s % len;
    blk = s - off;
    if (il != 0) return blk + (off ^ k);
    return blk + ((off + k) % len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_last = 0; m_err = 0;
    end else if (cke) begin
      int code, bad;
      code = int'(mode_word[2:0]);
      bad = (code >= 4 && code <= 6) || (code == 7 && mode_word[3]);
      m_err = start && bad;
      if (start && !bad) begin
        if (is_write && mode_word[9]) m_len = 1;
        else if (code == 7) m_len = 0;
        else m_len = 1 << code;
        m_start = int'(start_col); m_ilv = int'(mode_word[3]); m_beat = 0;
        m_valid = 1; m_last = (m_len == 1);
        m_addr = m_start;
      end else if (m_valid && (stop || m_last)) begin
        m_valid = 0; m_last = 0;
      end else if (m_valid) begin
        m_beat++;
        m_addr = addr_of(m_start, m_beat, m_len, m_ilv);
        m_last = (m_len != 0) && (m_beat == m_len - 1);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("valid", int'(valid), m_valid);
      chk("last", int'(last), m_last);
      chk("mode_err", int'(mode_err), m_err);
      if (m_valid) chk("col_addr", int'(col_addr), m_addr);
      if (last) seen_last++;
    end
  end

  task automatic drive(bit s, bit w, bit p, bit c);
    @(negedge clk);
    start = s; is_write = w; stop = p; cke = c;
  endtask

  task automatic burst(string t, logic [9:0] mw, logic [7:0] col, bit w, int idle);
    tag = t;
    @(negedge clk);
    mode_word = mw; start_col = col; is_write = w; start = 1'b1; stop = 1'b0; cke = 1'b1;
    for (int i = 0; i < idle; i++) drive(0, 0, 0, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("reset valid", int'(valid), 0);
    chk("reset last", int'(last), 0);
    chk("reset mode_err", int'(mode_err), 0);
    rst_n = 1'b1;
    drive(0, 0, 0, 1);

    burst("R2", 10'h000, 8'h3A, 0, 3);   // length 1
    burst("R2", 10'h001, 8'h07, 0, 4);   // length 2
    burst("R3", 10'h002, 8'h41, 0, 6);   // length 4 seq from 01
    burst("R3", 10'h003, 8'h35, 0, 10);  // length 8 seq from 101
    burst("R4", 10'h00B, 8'h5D, 0, 10);  // length 8 interleave from 101
    burst("R4", 10'h00A, 8'hC3, 0, 6);   // length 4 interleave from 11

    seen_last = 0;
    burst("R5", 10'h007, 8'hFE, 0, 300);
    tag = "R5";
    chk("full page raised last", seen_last, 0);
    tag = "R8";
    drive(0, 0, 1, 1);
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);

    burst("R6", 10'h202, 8'h12, 1, 3);   // single write
    burst("R6", 10'h202, 8'h12, 0, 6);   // read keeps length 4
    burst("R6", 10'h207, 8'h80, 1, 3);   // single write even in full page

    burst("R7", 10'h004, 8'h11, 0, 3);
    burst("R7", 10'h006, 8'h11, 0, 3);
    burst("R7", 10'h00F, 8'h11, 0, 3);
    burst("R7", 10'h003, 8'h20, 0, 2);
    burst("R7", 10'h005, 8'h90, 0, 8);   // illegal start mid-burst: ignored

    burst("R8", 10'h003, 8'h48, 0, 2);
    drive(0, 0, 1, 1);
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 1);

    burst("R9", 10'h003, 8'h66, 0, 2);
    tag = "R9";
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drive(0, 0, 0, 1);

    burst("R10", 10'h003, 8'h10, 0, 3);
    tag = "R10";
    @(negedge clk);
    mode_word = 10'h00A; start_col = 8'hE6; start = 1'b1; stop = 1'b1;
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule